// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous static memory that accepts one command on every enabled clock edge. Each command is a read or a write, and any mix or order is allowed. It never asks the requester to wait, so a write may follow a read and a read may follow a write at full rate. Each word is 18 bits wide and is split into two 9-bit lanes. The write depth is set by an address-width parameter; a value of 17 gives the full 128K-word array.

The address phase and the data phase are separated by one enabled clock. The address, the write request and the three chip selects are registered on an edge. The write data and its lane selects are registered on the next enabled edge and held in a pending-write register, which commits to the array on the enabled edge after that. A read that targets the address of the pending write sees that write's new lanes merged over the stored word. Read data is flow-through: it is driven combinationally from the registered read address during the cycle after the command is sampled.

A low clock enable freezes every register, so the cycle appears extended. A separate output-enable input can disable the output at any time without waiting for a clock edge. Whenever the output is not driven, the data port reads as zero.

Top module: `zbt_sram_core`

## Requirements
- R1: The word is 18 bits, made of lane A (bits 8:0) and lane B (bits 17:9). The depth is 2^ADDR_W words. A full write followed later by a read of the same address returns the written word.
- R2: A read command is sampled on a rising edge. Its data appears on `rdata` with `rdata_drive` high during the clock cycle that follows that edge, with no further register stage.
- R3: While `clk_en` is low, no internal state changes. Any pending command, pending write data and the output all hold until the next enabled edge, as if the previous cycle had been stretched.
- R4: The write data and the lane selects of a write are taken on the first enabled edge after the edge that took its address. Values presented during stalled cycles are ignored.
- R5: In `lane_wr`, bit 0 enables lane A and bit 1 enables lane B. A lane whose bit is 0 keeps its stored value, and a write with both bits 0 changes nothing.
- R6: A command is accepted only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination performs no access: it writes nothing and leaves the output undriven in the following cycle.
- R7: Read and write commands may arrive on consecutive enabled edges in any order. Each one completes with no idle cycle in between.
- R8: During the cycle that follows a write command, which is its data phase, `rdata_drive` is low.
- R9: When `out_en` is low, `rdata_drive` is low and `rdata` is zero at once, with no clock edge needed, whatever the read state.
- R10: A read to the address of a write whose data has been taken but not yet committed returns the new lanes of that write, merged with the stored contents of the other lanes.
- R11: After a synchronous reset, no command and no write is pending. `rdata_drive` is low, and `rdata` is zero while undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock qualifier; low stalls the whole block |
| addr | input | ADDR_W | Command word address |
| wr_req | input | 1 | High for a write command, low for a read command |
| lane_wr | input | 2 | Lane write enables, taken in the data phase (bit 0 lane A, bit 1 lane B) |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| out_en | input | 1 | Asynchronous output enable, active high |
| wdata | input | 18 | Write data, taken in the data phase |
| rdata | output | 18 | Flow-through read data, zero when undriven |
| rdata_drive | output | 1 | High when the core drives `rdata` |

## Verification
The pending-write register and the forwarding compare show a fault the first time a read follows a write to the same address. A wrong lane mask or a missed merge then returns stale bits in that same cycle. A fault in the stall gating shows one enabled edge later, as a shifted or corrupted data phase, because the data belongs to a different write. A wrong chip-select decode or a wrong drive term shows on `rdata_drive` in the cycle right after the command. Mixed, randomized traffic that includes stalls and output-enable toggles is compared on every clock against a behavioural model, so a divergence is caught within one or two cycles of its cause.

// File: rtl/zbt_sram_pkg.sv
`timescale 1ns/1ps
package zbt_sram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef struct packed {
    logic valid;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/zbt_cmd_stage.sv
`timescale 1ns/1ps
module zbt_cmd_stage
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  output cmd_t              cmd_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic chip_on;
  assign chip_on = ~sel1_n & sel2 & ~sel3_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else if (clk_en) begin
      cmd_q.valid <= chip_on;
      cmd_q.wr    <= wr_req;
      addr_q      <= addr;
    end
  end
endmodule

// File: rtl/zbt_wr_stage.sv
`timescale 1ns/1ps
module zbt_wr_stage
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  cmd_t              cmd_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_wr,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data,
  output logic [LANES-1:0]  pend_mask
);
  logic take;
  assign take = cmd_q.valid & cmd_q.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_mask  <= '0;
    end else if (clk_en) begin
      pend_valid <= take;
      pend_addr  <= addr_q;
      pend_data  <= wdata;
      pend_mask  <= lane_wr & {LANES{take}};
    end
  end
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              clk_en,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (clk_en && we && wmask[g])
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/zbt_sram_core.sv
`timescale 1ns/1ps
module zbt_sram_core
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_req,
  input  logic [1:0]        lane_wr,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              out_en,
  input  logic [17:0]       wdata,
  output logic [17:0]       rdata,
  output logic              rdata_drive
);
  cmd_t              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cmd_valid;
  logic              cmd_wr;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [LANES-1:0]  pend_mask;
  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] merged;
  logic              fwd_hit;

  assign cmd_valid = cmd_q.valid;
  assign cmd_wr    = cmd_q.wr;

  zbt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .sel1_n (sel1_n),
    .sel2   (sel2),
    .sel3_n (sel3_n),
    .wr_req (wr_req),
    .addr   (addr),
    .cmd_q  (cmd_q),
    .addr_q (addr_q)
  );

  zbt_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .cmd_q      (cmd_q),
    .addr_q     (addr_q),
    .wdata      (wdata),
    .lane_wr    (lane_wr),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_data  (pend_data),
    .pend_mask  (pend_mask)
  );

  zbt_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk    (clk),
    .clk_en (clk_en),
    .we     (pend_valid),
    .waddr  (pend_addr),
    .wmask  (pend_mask),
    .wdata  (pend_data),
    .raddr  (addr_q),
    .rdata  (arr_rd)
  );

  // Forward the uncommitted write lane by lane over the stored word.
  assign fwd_hit = pend_valid && (pend_addr == addr_q);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && pend_mask[g])
                                      ? pend_data[g*LANE_W +: LANE_W]
                                      : arr_rd[g*LANE_W +: LANE_W];
  end

  assign rdata_drive = out_en & cmd_valid & ~cmd_wr;
  assign rdata       = rdata_drive ? merged : '0;
endmodule

// File: rtl/zbt_sram_core_chk.sv
`timescale 1ns/1ps
module zbt_sram_core_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              wr_req,
  input logic              out_en,
  input logic [17:0]       rdata,
  input logic              rdata_drive,
  input logic              cmd_valid,
  input logic              cmd_wr,
  input logic [ADDR_W-1:0] addr_q,
  input logic              pend_valid
);
  logic sel_ok;
  assign sel_ok = ~sel1_n & sel2 & ~sel3_n;

  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(cmd_valid) && $stable(cmd_wr) && $stable(addr_q) && $stable(pend_valid));

  p_data_phase_r4: assert property (@(posedge clk) disable iff (rst)
    clk_en && cmd_valid && cmd_wr |=> pend_valid);

  p_desel_r6: assert property (@(posedge clk) disable iff (rst)
    clk_en && !sel_ok |=> !rdata_drive);

  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    clk_en && sel_ok && !wr_req |=> (rdata_drive || !out_en));

  p_write_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_wr |-> !rdata_drive);

  p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> !rdata_drive && rdata == 18'd0);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !rdata_drive |-> rdata == 18'd0);
endmodule

bind zbt_sram_core zbt_sram_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clk_en      (clk_en),
  .sel1_n      (sel1_n),
  .sel2        (sel2),
  .sel3_n      (sel3_n),
  .wr_req      (wr_req),
  .out_en      (out_en),
  .rdata       (rdata),
  .rdata_drive (rdata_drive),
  .cmd_valid   (cmd_valid),
  .cmd_wr      (cmd_wr),
  .addr_q      (addr_q),
  .pend_valid  (pend_valid)
);

// File: tb/zbt_sram_core_bench.sv
`timescale 1ns/1ps
module zbt_sram_core_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_req = 1'b0;
  logic [1:0]    lane_wr = 2'b00;
  logic          sel1_n = 1'b1;
  logic          sel2 = 1'b0;
  logic          sel3_n = 1'b1;
  logic          out_en = 1'b0;
  logic [17:0]   wdata = '0;
  logic [17:0]   rdata;
  logic          rdata_drive;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Behavioural reference: word store plus the last accepted command.
  logic [17:0] mdl [int];
  bit          m_valid = 1'b0;
  bit          m_wr    = 1'b0;
  int          m_addr  = 0;

  always #2.5 clk = ~clk;

  zbt_sram_core #(.ADDR_W(AW)) u_zbt_sram_core (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr), .wr_req(wr_req),
    .lane_wr(lane_wr), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .out_en(out_en), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  function automatic logic [17:0] pat(input int i);
    return 18'h2A5A5 ^ 18'(i * 32'h137);
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic compare(input string tag);
    logic        e_drv;
    logic [17:0] e_dat;
    e_drv = out_en && m_valid && !m_wr;
    e_dat = (e_drv && mdl.exists(m_addr)) ? mdl[m_addr] : 18'd0;
    n_cmp++;
    if (rdata_drive !== e_drv || rdata !== e_dat) begin
      n_bad++;
      $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
               tag, rdata_drive, rdata, e_drv, e_dat);
    end
  endtask

  task automatic cyc(input bit ce, input bit s1n, input bit s2, input bit s3n,
                     input bit wr, input int a, input logic [1:0] ln,
                     input logic [17:0] wd, input bit oe, input string tag);
    clk_en = ce; sel1_n = s1n; sel2 = s2; sel3_n = s3n; wr_req = wr;
    addr = AW'(a); lane_wr = ln; wdata = wd; out_en = oe;
    @(posedge clk);
    #1;
    if (rst) begin
      m_valid = 1'b0;
      m_wr    = 1'b0;
    end else if (ce) begin
      if (m_valid && m_wr) begin
        logic [17:0] o;
        o = mdl.exists(m_addr) ? mdl[m_addr] : 18'd0;
        if (ln[0]) o[8:0]  = wd[8:0];
        if (ln[1]) o[17:9] = wd[17:9];
        if (ln != 2'b00) mdl[m_addr] = o;
      end
      m_valid = !s1n && s2 && !s3n;
      m_wr    = wr;
      m_addr  = a;
    end
    #1;
    compare(tag);
  endtask

  task automatic op(input bit wr, input int a, input logic [1:0] ln,
                    input logic [17:0] wd, input string tag);
    cyc(1, 0, 1, 0, wr, a, ln, wd, 1, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    report();
  end

  initial begin
    // R11: reset state with output enable high
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 0, 0, 2'b11, 18'd0, 1, "R11");
    rst = 1'b0;
    cyc(1, 1, 0, 1, 0, 0, 2'b00, 18'd0, 1, "R11");

    // R7 / R1: back-to-back full-word writes to addresses 0..15
    for (int i = 0; i < 16; i++) op(1, i, 2'b11, (i > 0) ? pat(i - 1) : 18'd0, "R7");
    op(0, 0, 2'b11, pat(15), "R1");
    // R2: flow-through reads
    for (int i = 0; i < 16; i++) op(0, i, 2'b00, 18'd0, "R2");

    // R10 / R8: write then immediate read of the same word
    for (int i = 0; i < 6; i++) begin
      op(1, i + 8, 2'b00, 18'd0, "R8");
      op(0, i + 8, 2'b11, pat(100 + i), "R10");
    end
    // R10: partial forward merges one new lane over the stored lane
    op(1, 9, 2'b00, 18'd0, "R8");
    op(0, 9, 2'b10, 18'h3FFFF, "R10");

    // R5: lane masking
    op(1, 3, 2'b00, 18'd0, "R5");
    op(1, 4, 2'b01, 18'h15555, "R5");
    op(1, 5, 2'b10, 18'h0AAAA, "R5");
    op(0, 3, 2'b00, 18'h3FFFF, "R5");
    op(0, 4, 2'b00, 18'd0, "R5");
    op(0, 5, 2'b00, 18'd0, "R5");

    // R6: each chip select inactive in turn
    cyc(1, 1, 1, 0, 1, 6, 2'b00, 18'd0, 1, "R6");
    cyc(1, 0, 0, 0, 1, 6, 2'b11, 18'h3FFFF, 1, "R6");
    cyc(1, 0, 1, 1, 1, 6, 2'b11, 18'h3FFFF, 1, "R6");
    cyc(1, 0, 1, 1, 0, 6, 2'b11, 18'h3FFFF, 1, "R6");
    op(0, 6, 2'b11, 18'h3FFFF, "R6");

    // R3 / R4: stall between address and data phase
    op(1, 7, 2'b00, 18'd0, "R3");
    cyc(0, 0, 1, 0, 0, 8, 2'b11, 18'h11111, 1, "R3");
    cyc(0, 0, 1, 0, 1, 2, 2'b01, 18'h22222, 1, "R3");
    cyc(0, 1, 0, 1, 0, 9, 2'b10, 18'h33333, 1, "R3");
    op(0, 7, 2'b11, 18'h0ABCD, "R4");
    // R3: stall during a read holds the output
    op(0, 2, 2'b00, 18'd0, "R3");
    cyc(0, 0, 1, 0, 1, 2, 2'b11, 18'h3FFFF, 1, "R3");
    cyc(0, 1, 1, 1, 1, 5, 2'b11, 18'h3FFFF, 1, "R3");
    op(0, 2, 2'b11, 18'h3FFFF, "R3");

    // R9: asynchronous output enable
    cyc(1, 0, 1, 0, 0, 1, 2'b00, 18'd0, 0, "R9");
    out_en = 1'b1; #1; compare("R9");
    out_en = 1'b0; #1; compare("R9");
    op(0, 1, 2'b00, 18'd0, "R9");

    // R7: randomized mixed traffic
    for (int i = 0; i < 400; i++) begin
      bit  ce, s1n, s2, s3n, oe;
      ce  = ($urandom % 6) != 0;
      s1n = ($urandom % 10) == 0;
      s2  = ($urandom % 10) != 0;
      s3n = ($urandom % 10) == 0;
      oe  = ($urandom % 8) != 0;
      cyc(ce, s1n, s2, s3n, 1'($urandom), int'($urandom % 16), 2'($urandom),
          18'($urandom), oe, "R7");
    end

    report();
  end
endmodule